// File: doc/BRIEF.md
# SMBus Register Target Responder

This block is the transaction layer of an SMBus target device. It sits behind a byte-level I2C slave engine that has already handled the wires, the start and stop detection and the address comparison. That engine reports five kinds of event, each as a one-cycle pulse: an address match with its read/write bit, a received byte, a request for the next byte to transmit, the master's acknowledge or not-acknowledge of a transmitted byte, and a stop condition. The responder answers a received byte with an ACK/NACK decision in the same cycle, and it supplies the transmit byte in the same cycle as the request.

The first byte written after a write address is a command code. A code below `NREG` selects one of the 16-bit word registers. The code `BLK_CMD` (0x80 by default) selects a block buffer of up to `MAX_BLK` bytes. The selected code persists across transactions as a command pointer. A bare read, which has no command phase, is served from the register that the most recent accepted command selected. A write address that carries only a command byte moves the pointer and nothing else.

Top module: `smbus_resp`

## Requirements
- R1: After reset, every word register, the block length and the command pointer are zero, so a bare read returns 0x00 as its first byte.
- R2: The first byte received after a write address is a command. It is ACKed and stored as the pointer when it is below NREG or equal to 0x80. Any other value is NACKed and leaves the pointer unchanged.
- R3: For a word command, the first data byte replaces the register's low byte and leaves the high byte unchanged. The second data byte replaces the high byte. Every further byte is NACKed and changes nothing.
- R4: A read of a word register transmits the low byte, then the high byte, then 0xFF for every later request.
- R5: A master NACK ends the read. From the NACK cycle until the next address, every transmit request returns 0xFF, including one that arrives in the same cycle as the NACK. The pointer is kept.
- R6: A read address that follows a stop, with no command phase in between, serves the register named by the last accepted command, starting at its first byte.
- R7: A repeated start after a command byte keeps that command, so the read phase serves the register it selected.
- R8: For command 0x80, the first data byte is a count and is stored as the block length, clamped to MAX_BLK. The following bytes are ACKed and stored at positions 0, 1, 2 and onward, up to MAX_BLK bytes.
- R9: A block-write data byte beyond position MAX_BLK-1 is NACKed, drives `blk_ovf` high in that same cycle, and changes no stored byte.
- R10: A read of command 0x80 transmits the stored length, then exactly that many stored bytes in order, then 0xFF.
- R11: After a stop and before the next address, a received byte is NACKed and a transmit request returns 0xFF.
- R12: When a master ACK and the next transmit request arrive in the same cycle, the byte returned is the next byte in sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ev | input | 1 | Address-match pulse from the slave engine |
| addr_rd | input | 1 | Direction bit of the matched address, 1 = read |
| rx_ev | input | 1 | Received-byte pulse |
| rx_byte | input | 8 | Received byte, valid with rx_ev |
| rx_ack | output | 1 | ACK decision for the byte in rx_ev's cycle |
| tx_ev | input | 1 | Request for the next transmit byte |
| tx_byte | output | 8 | Transmit byte, valid in tx_ev's cycle |
| mack_ev | input | 1 | Master response to a transmitted byte |
| mack_nack | input | 1 | 1 when that response is a NACK |
| stop_ev | input | 1 | Stop-condition pulse |
| blk_ovf | output | 1 | High with a block-write byte rejected for lack of space |

## Verification
The master's response to one byte and the request for the following byte can land in the same cycle. When the response is an ACK, the byte returned in that cycle must already be the next one in the sequence. When it is a NACK, the transmit byte must fall to 0xFF in that very cycle and not one cycle later. The bench pairs the two pulses on every byte after the first in its word and block read sweeps, and it also issues a NACK together with a request. It judges each case against a byte sequence that it computes itself from the register and block contents it has written.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

  typedef enum logic [2:0] {
    P_IDLE,   // no transaction, or one ended by stop
    P_CMD,    // write address seen, waiting for command
    P_WDAT,   // command accepted, taking data bytes
    P_RD,     // serving transmit requests
    P_DONE    // read ended by NACK or command refused
  } phase_e;

  // pick one byte lane of a word register
  function automatic logic [7:0] word_lane(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  // clamp a count byte to a limit
  function automatic logic [7:0] clamp8(input logic [7:0] c, input logic [7:0] lim);
    return (c > lim) ? lim : c;
  endfunction

endpackage

// File: rtl/smbr_regfile.sv
module smbr_regfile #(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [RW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [RW-1:0] raddr,
  output logic [15:0]   rdata
);

  logic [15:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[g] <= 16'h0000;
      end else if (waddr == RW'(g)) begin
        if (we_lo) mem[g][7:0]  <= wdata;
        if (we_hi) mem[g][15:8] <= wdata;
      end
    end
  end

  assign rdata = mem[raddr];

  // R3: a data byte lands in exactly one lane
  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_lo && we_hi));

endmodule

// File: rtl/smbr_blkbuf.sv
module smbr_blkbuf #(
  parameter int MAX_BLK = 32,
  localparam int IW  = $clog2(MAX_BLK + 2),
  localparam int BAW = $clog2(MAX_BLK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           len_we,
  input  logic [IW-1:0]  len_in,
  input  logic           we,
  input  logic [BAW-1:0] waddr,
  input  logic [7:0]     wdata,
  input  logic [BAW-1:0] raddr,
  output logic [7:0]     rbyte,
  output logic [IW-1:0]  len
);

  logic [7:0] mem [MAX_BLK];

  always_ff @(posedge clk) begin
    if (!rst_n) len <= '0;
    else if (len_we) len <= len_in;
  end

  for (genvar g = 0; g < MAX_BLK; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= 8'h00;
      else if (we && waddr == BAW'(g)) mem[g] <= wdata;
    end
  end

  assign rbyte = mem[raddr];

  // R8: stored length never exceeds the buffer
  a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    len <= IW'(MAX_BLK));

endmodule

// File: rtl/smbr_seq.sv
module smbr_seq
  import smbr_pkg::*;
#(
  parameter int          NREG    = 4,
  parameter int          MAX_BLK = 32,
  parameter logic [7:0]  BLK_CMD = 8'h80,
  localparam int RW  = $clog2(NREG),
  localparam int IW  = $clog2(MAX_BLK + 2),
  localparam int BAW = $clog2(MAX_BLK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_addr,
  input  logic           ev_addr_rd,
  input  logic           ev_rx,
  input  logic [7:0]     ev_rx_byte,
  output logic           rx_ack,
  input  logic           ev_tx,
  output logic [7:0]     tx_byte,
  input  logic           ev_mack,
  input  logic           ev_mack_nack,
  input  logic           ev_stop,
  output logic           ovf,
  // register file
  output logic           reg_we_lo,
  output logic           reg_we_hi,
  output logic [RW-1:0]  reg_addr,
  input  logic [15:0]    reg_rdata,
  // block buffer
  output logic           blk_len_we,
  output logic [IW-1:0]  blk_len_in,
  output logic           blk_we,
  output logic [BAW-1:0] blk_waddr,
  output logic [BAW-1:0] blk_raddr,
  input  logic [7:0]     blk_rbyte,
  input  logic [IW-1:0]  blk_len
);

  localparam logic [7:0]    NREG8   = 8'(NREG);
  localparam logic [7:0]    MAX8    = 8'(MAX_BLK);
  localparam logic [IW-1:0] IDX_MAX = IW'(MAX_BLK);
  localparam logic [IW-1:0] IDX_SAT = IW'(MAX_BLK + 1);

  phase_e        st;
  logic [7:0]    cmd_ptr;
  logic [IW-1:0] idx;

  // named internal events
  logic is_blk, cmd_ok, rx_cmd, rx_dat, nack_now, rd_live, tx_step;
  logic [IW-1:0] idx_inc;

  assign is_blk   = (cmd_ptr == BLK_CMD);
  assign cmd_ok   = (ev_rx_byte < NREG8) || (ev_rx_byte == BLK_CMD);
  assign rx_cmd   = ev_rx && (st == P_CMD);
  assign rx_dat   = ev_rx && (st == P_WDAT);
  assign nack_now = ev_mack && ev_mack_nack;
  assign rd_live  = (st == P_RD) && !nack_now;
  assign tx_step  = ev_tx && rd_live;
  assign idx_inc  = (idx == IDX_SAT) ? idx : idx + 1'b1;

  // write side
  assign reg_we_lo  = rx_dat && !is_blk && (idx == '0);
  assign reg_we_hi  = rx_dat && !is_blk && (idx == IW'(1));
  assign blk_len_we = rx_dat && is_blk && (idx == '0);
  assign blk_we     = rx_dat && is_blk && (idx != '0) && (idx <= IDX_MAX);
  assign ovf        = rx_dat && is_blk && (idx > IDX_MAX);
  assign blk_len_in = IW'(clamp8(ev_rx_byte, MAX8));
  assign blk_waddr  = BAW'(idx - 1'b1);
  assign reg_addr   = cmd_ptr[RW-1:0];

  assign rx_ack = (rx_cmd && cmd_ok) || reg_we_lo || reg_we_hi
                  || blk_len_we || blk_we;

  // transmit side
  assign blk_raddr = BAW'(idx - 1'b1);

  always_comb begin
    tx_byte = 8'hFF;
    if (rd_live) begin
      if (is_blk) begin
        if (idx == '0)           tx_byte = 8'(blk_len);
        else if (idx <= blk_len) tx_byte = blk_rbyte;
      end else begin
        if (idx == '0)           tx_byte = word_lane(reg_rdata, 1'b0);
        else if (idx == IW'(1))  tx_byte = word_lane(reg_rdata, 1'b1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= P_IDLE;
      cmd_ptr <= 8'h00;
      idx     <= '0;
    end else if (ev_addr) begin
      st  <= ev_addr_rd ? P_RD : P_CMD;
      idx <= '0;
    end else if (ev_stop) begin
      st <= P_IDLE;
    end else begin
      if (rx_cmd) begin
        if (cmd_ok) begin
          cmd_ptr <= ev_rx_byte;
          st      <= P_WDAT;
          idx     <= '0;
        end else begin
          st <= P_DONE;
        end
      end
      if (rx_dat) idx <= idx_inc;
      if (tx_step) idx <= idx_inc;
      if (nack_now && st == P_RD) st <= P_DONE;
    end
  end

  // R9: a rejected block byte is never acknowledged
  a_r9_ovf_nack: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !rx_ack);

  // R2: the pointer moves only on a command byte
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rx && st == P_CMD) |=> $stable(cmd_ptr));

  // R11: stop returns to idle
  a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_addr) |=> (st == P_IDLE));

  // R5: an ended read only offers released-bus bytes
  a_r5_done_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_DONE) |-> (tx_byte == 8'hFF));

endmodule

// File: rtl/smbus_resp.sv
module smbus_resp #(
  parameter int         NREG    = 4,
  parameter int         MAX_BLK = 32,
  parameter logic [7:0] BLK_CMD = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_ev,
  input  logic       addr_rd,
  input  logic       rx_ev,
  input  logic [7:0] rx_byte,
  output logic       rx_ack,
  input  logic       tx_ev,
  output logic [7:0] tx_byte,
  input  logic       mack_ev,
  input  logic       mack_nack,
  input  logic       stop_ev,
  output logic       blk_ovf
);

  localparam int RW  = $clog2(NREG);
  localparam int IW  = $clog2(MAX_BLK + 2);
  localparam int BAW = $clog2(MAX_BLK);

  logic           reg_we_lo, reg_we_hi;
  logic [RW-1:0]  reg_addr;
  logic [15:0]    reg_rdata;
  logic           blk_len_we, blk_we;
  logic [IW-1:0]  blk_len_in, blk_len;
  logic [BAW-1:0] blk_waddr, blk_raddr;
  logic [7:0]     blk_rbyte;

  smbr_seq #(.NREG(NREG), .MAX_BLK(MAX_BLK), .BLK_CMD(BLK_CMD)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ev_addr(addr_ev), .ev_addr_rd(addr_rd),
    .ev_rx(rx_ev), .ev_rx_byte(rx_byte), .rx_ack(rx_ack),
    .ev_tx(tx_ev), .tx_byte(tx_byte),
    .ev_mack(mack_ev), .ev_mack_nack(mack_nack),
    .ev_stop(stop_ev), .ovf(blk_ovf),
    .reg_we_lo(reg_we_lo), .reg_we_hi(reg_we_hi),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .blk_len_we(blk_len_we), .blk_len_in(blk_len_in),
    .blk_we(blk_we), .blk_waddr(blk_waddr),
    .blk_raddr(blk_raddr), .blk_rbyte(blk_rbyte), .blk_len(blk_len)
  );

  smbr_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_lo(reg_we_lo), .we_hi(reg_we_hi),
    .waddr(reg_addr), .wdata(rx_byte),
    .raddr(reg_addr), .rdata(reg_rdata)
  );

  smbr_blkbuf #(.MAX_BLK(MAX_BLK)) u_blk (
    .clk(clk), .rst_n(rst_n),
    .len_we(blk_len_we), .len_in(blk_len_in),
    .we(blk_we), .waddr(blk_waddr), .wdata(rx_byte),
    .raddr(blk_raddr), .rbyte(blk_rbyte), .len(blk_len)
  );

endmodule

// File: tb/smbus_resp_tb.sv
module smbus_resp_tb;

  localparam int NREG = 4;
  localparam int MAXB = 32;

  logic clk = 0, rst_n = 0;
  logic addr_ev = 0, addr_rd = 0, rx_ev = 0, tx_ev = 0;
  logic mack_ev = 0, mack_nack = 0, stop_ev = 0;
  logic [7:0] rx_byte = 0;
  logic rx_ack, blk_ovf;
  logic [7:0] tx_byte;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [15:0] m_reg [NREG];
  logic [7:0]  m_blk [MAXB];
  int          m_len;

  always #5 clk = ~clk;

  smbus_resp u_dut (
    .clk(clk), .rst_n(rst_n), .addr_ev(addr_ev), .addr_rd(addr_rd),
    .rx_ev(rx_ev), .rx_byte(rx_byte), .rx_ack(rx_ack),
    .tx_ev(tx_ev), .tx_byte(tx_byte), .mack_ev(mack_ev),
    .mack_nack(mack_nack), .stop_ev(stop_ev), .blk_ovf(blk_ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic pulse_end();
    @(posedge clk); #1;
    addr_ev = 0; rx_ev = 0; tx_ev = 0; mack_ev = 0; mack_nack = 0; stop_ev = 0;
  endtask

  task automatic do_addr(input bit rd);
    @(negedge clk); addr_ev = 1; addr_rd = rd; pulse_end();
  endtask

  task automatic do_stop();
    @(negedge clk); stop_ev = 1; pulse_end();
  endtask

  task automatic do_nack();
    @(negedge clk); mack_ev = 1; mack_nack = 1; pulse_end();
  endtask

  // receive one byte, checking ack and overflow
  task automatic do_rx(input logic [7:0] b, input bit e_ack, input bit e_ovf, input string tag);
    @(negedge clk); rx_ev = 1; rx_byte = b; #1;
    chk(rx_ack == e_ack, {tag, " ack"}, int'(rx_ack), int'(e_ack));
    chk(blk_ovf == e_ovf, {tag, " ovf"}, int'(blk_ovf), int'(e_ovf));
    pulse_end();
  endtask

  // transmit request, optionally with a master response in the same cycle
  task automatic do_tx(input logic [7:0] e, input bit with_mack, input bit nk, input string tag);
    @(negedge clk); tx_ev = 1; mack_ev = with_mack; mack_nack = nk; #1;
    chk(tx_byte == e, tag, int'(tx_byte), int'(e));
    pulse_end();
  endtask

  function automatic logic [7:0] pat_lo(input int r); return 8'((r * 37 + 5) & 255); endfunction
  function automatic logic [7:0] pat_hi(input int r); return 8'((r * 91 + 160) & 255); endfunction
  function automatic logic [7:0] pat_blk(input int n, input int i);
    return 8'((i * 13 + n * 5 + 1) & 255);
  endfunction

  // read a whole word register after a command and repeated start
  task automatic read_word(input int r, input string tag);
    do_addr(0); do_rx(8'(r), 1, 0, {tag, " R2 cmd"});
    do_addr(1);
    do_tx(m_reg[r][7:0], 0, 0, {tag, " R7 low"});
    do_tx(m_reg[r][15:8], 1, 0, {tag, " R12 high"});
    do_tx(8'hFF, 1, 0, {tag, " R4 past end"});
    do_nack(); do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NREG; r++) m_reg[r] = 16'h0;
    for (int i = 0; i < MAXB; i++) m_blk[i] = 8'h0;
    m_len = 0;
    repeat (3) @(posedge clk); #1; rst_n = 1;

    // R1: reset state through a bare read and a block read
    do_addr(1);
    do_tx(8'h00, 0, 0, "R1 reset reg0 low");
    do_tx(8'h00, 1, 0, "R1 reset reg0 high");
    do_nack(); do_stop();
    do_addr(0); do_rx(8'h80, 1, 0, "R1 blk cmd"); do_addr(1);
    do_tx(8'h00, 0, 0, "R1 reset length");
    do_tx(8'hFF, 1, 0, "R1 empty block");
    do_nack(); do_stop();

    // R3: full word writes, extra byte refused
    for (int r = 0; r < NREG; r++) begin
      do_addr(0);
      do_rx(8'(r), 1, 0, "R2 word cmd");
      do_rx(pat_lo(r), 1, 0, "R3 low byte");
      do_rx(pat_hi(r), 1, 0, "R3 high byte");
      do_rx(8'h5A, 0, 0, "R3 extra byte");
      do_stop();
      m_reg[r] = {pat_hi(r), pat_lo(r)};
    end
    for (int r = 0; r < NREG; r++) read_word(r, "sweep");

    // R3: single-byte write keeps high byte
    do_addr(0); do_rx(8'h02, 1, 0, "R2 cmd 2"); do_rx(8'hC3, 1, 0, "R3 one byte"); do_stop();
    m_reg[2][7:0] = 8'hC3;
    read_word(2, "R3 single");

    // R6: bare read serves last command (2), then a command-only write to 1
    do_addr(1);
    do_tx(m_reg[2][7:0], 0, 0, "R6 bare read last cmd");
    do_nack(); do_stop();
    do_addr(0); do_rx(8'h01, 1, 0, "R7 cmd only"); do_stop();
    do_addr(1);
    do_tx(m_reg[1][7:0], 0, 0, "R6 bare read after cmd only");
    do_nack(); do_stop();

    // R2: unknown command refused, pointer kept
    do_addr(0); do_rx(8'h10, 0, 0, "R2 bad cmd"); do_rx(8'h77, 0, 0, "R2 data after bad cmd"); do_stop();
    do_addr(1);
    do_tx(m_reg[1][7:0], 0, 0, "R2 pointer kept");
    do_nack(); do_stop();
    read_word(1, "R2 reg1 untouched");

    // R5: NACK with a request in the same cycle, then pointer kept
    do_addr(0); do_rx(8'h00, 1, 0, "R2 cmd 0"); do_addr(1);
    do_tx(m_reg[0][7:0], 0, 0, "R5 first byte");
    do_tx(8'hFF, 1, 1, "R5 nack same cycle");
    do_tx(8'hFF, 0, 0, "R5 after nack");
    do_stop();
    do_addr(1);
    do_tx(m_reg[0][7:0], 0, 0, "R5 pointer kept");
    do_nack(); do_stop();

    // R11: after stop, bytes refused and transmit released
    do_rx(8'h33, 0, 0, "R11 rx after stop");
    do_tx(8'hFF, 0, 0, "R11 tx after stop");
    read_word(0, "R11 reg0 untouched");

    // R8 R10: block sweep over every length
    for (int n = 0; n <= MAXB; n++) begin
      do_addr(0); do_rx(8'h80, 1, 0, "R2 blk cmd");
      do_rx(8'(n), 1, 0, "R8 count");
      for (int i = 0; i < n; i++) begin
        do_rx(pat_blk(n, i), 1, 0, "R8 data");
        m_blk[i] = pat_blk(n, i);
      end
      do_stop();
      m_len = n;
      do_addr(0); do_rx(8'h80, 1, 0, "R2 blk cmd rd"); do_addr(1);
      do_tx(8'(m_len), 0, 0, "R10 length");
      for (int i = 0; i < m_len; i++) do_tx(m_blk[i], 1, 0, "R10 data");
      do_tx(8'hFF, 1, 0, "R10 past end");
      do_nack(); do_stop();
    end

    // R9: overflow with a clamped count
    do_addr(0); do_rx(8'h80, 1, 0, "R2 blk cmd ovf");
    do_rx(8'd40, 1, 0, "R8 big count");
    for (int i = 0; i < MAXB + 2; i++) begin
      if (i < MAXB) begin
        do_rx(pat_blk(99, i), 1, 0, "R9 in range");
        m_blk[i] = pat_blk(99, i);
      end else begin
        do_rx(8'hEE, 0, 1, "R9 overflow byte");
      end
    end
    do_stop();
    m_len = MAXB;
    do_addr(1);
    do_tx(8'(m_len), 0, 0, "R8 clamped length bare read");
    for (int i = 0; i < m_len; i++) do_tx(m_blk[i], 1, 0, "R9 data unchanged");
    do_tx(8'hFF, 1, 0, "R10 end after full");
    do_nack(); do_stop();

    finish_run();
  end

endmodule